// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block is a sampled digital phase-frequency detector for a clock-generation loop. It watches a reference clock and a divided feedback clock, both treated as asynchronous to a fast system clock. Each input is brought into the fast domain through a flop synchroniser, and its rising transitions are turned into single-cycle events. A rising event on the reference raises the `up` request, meaning the oscillator is too slow. A rising event on the feedback raises the `dn` request, meaning the oscillator is too fast. Both requests feed a downstream charge pump.

The detector remembers which input moved first, so it steers both frequency and phase over a full cycle of phase error. The state in which both requests are raised is never kept. A mutual-clear timer drops both requests together once they have overlapped for `reset_delay + 1` fast-clock cycles. Because of this enforced overlap, every edge pair gives a pair of pulses of at least minimum width, even when the loop is locked, so the detector has no deadzone around zero phase error. Both inputs pass through identical synchroniser paths, so neither side gains a latency advantage.

Top module: `pfd_tri_state`

## Requirements
- R1: A rising transition on `ref_in` raises `up`, and one on `fb_in` raises `dn`. The request rises at the second `clk` edge after the first edge that samples the input high, when the previous edge sampled it low.
- R2: A request falls only while the other request is also raised (mutual clear). A request is never cleared on its own.
- R3: Once `up` and `dn` are both high, they stay high together for exactly `reset_delay + 1` cycles and then fall in the same cycle. With `reset_delay` = 0, they fall at the next edge.
- R4: If the reference leads by L cycles, `up` is high for L + `reset_delay` + 1 cycles and `dn` for `reset_delay` + 1 cycles. A lagging reference swaps the two widths, and coincident edges give equal widths of `reset_delay` + 1.
- R5: A rising input event that arrives while both requests are high, or in the clearing cycle, is held. Its request is high again straight after the clear, so the event is not lost.
- R6: While `rst_n` is low, `up` and `dn` read 0. The synchronisers and the clear timer restart from zero.
- R7: Further rising events on one input while only its own request is high are absorbed. A single event on the other input then returns both outputs to 0.
- R8: An input held at a constant level produces no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Divided feedback clock, asynchronous to clk |
| reset_delay | input | DLY_W (4) | Extra overlap cycles before the mutual clear |
| up | output | 1 | Speed-up request to the charge pump |
| dn | output | 1 | Slow-down request to the charge pump |

## Verification
Two functions can land in the same cycle: the mutual clear that ends an overlap, and a fresh rising event on one of the inputs. The bench provokes this with a long `reset_delay` and a second reference edge timed to arrive inside the overlap window. The held request must then still be high once the clear has happened. A behavioural model steps alongside the design and is compared on every cycle. Named checks also measure pulse widths for leading, lagging and coincident edges.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef struct packed {
      logic up;
      logic dn;
   } pfd_req_t;

   localparam int PFD_MIN_SYNC = 2;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] stage_q;
   logic              last_q;

   if (STAGES < pfd_pkg::PFD_MIN_SYNC) begin : g_bad_stages
      $error("pfd_edge_sync: STAGES below minimum");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= stage_q[LAST];
   end

   assign rise_o = stage_q[LAST] & ~last_q;

   // an event lasts one cycle; a held level gives no repeat (R8)
   assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_rst_timer.sv
module pfd_rst_timer #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             both_i,
   input  logic [DLY_W-1:0] delay_i,
   output logic             clear_o
);
   logic [DLY_W-1:0] cnt_q;

   if (DLY_W < 1) begin : g_bad_width
      $error("pfd_rst_timer: DLY_W must be positive");
   end

   assign clear_o = both_i & (cnt_q >= delay_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!both_i || clear_o) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

   // the overlap count never runs past the programmed delay (R3)
   assert_overlap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (both_i && $past(both_i) && $stable(delay_i)) |-> (cnt_q <= delay_i));
endmodule

// File: rtl/pfd_req_flop.sv
module pfd_req_flop #(
   parameter bit HOLD_EDGES = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic busy_i,
   input  logic clear_i,
   output logic req_o
);
   logic req_q;
   logic held;

   if (HOLD_EDGES) begin : g_hold
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       held_q <= 1'b0;
         else if (clear_i) held_q <= 1'b0;
         else if (busy_i && event_i) held_q <= 1'b1;
      end
      assign held = held_q;

      // a held event re-raises the request right after the clear (R5)
      assert_held_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clear_i && held_q) |=> req_q);
   end else begin : g_drop
      assign held = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       req_q <= 1'b0;
      else if (clear_i) req_q <= held | event_i;
      else              req_q <= req_q | event_i;
   end

   assign req_o = req_q;

   // a request only drops through the mutual clear (R2)
   assert_fall_by_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(clear_i));
endmodule

// File: rtl/pfd_tri_state.sv
module pfd_tri_state #(
   parameter int SYNC_STAGES = 2,
   parameter int DLY_W       = 4,
   parameter bit HOLD_EDGES  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             fb_in,
   input  logic [DLY_W-1:0] reset_delay,
   output logic             up,
   output logic             dn
);
   import pfd_pkg::*;

   pfd_req_t ev;
   pfd_req_t req;
   logic     both;
   logic     clear;

   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
      .clk(clk), .rst_n(rst_n), .async_i(ref_in), .rise_o(ev.up));
   pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
      .clk(clk), .rst_n(rst_n), .async_i(fb_in), .rise_o(ev.dn));

   assign both = req.up & req.dn;

   pfd_rst_timer #(.DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .both_i(both), .delay_i(reset_delay),
      .clear_o(clear));

   pfd_req_flop #(.HOLD_EDGES(HOLD_EDGES)) u_req_up (
      .clk(clk), .rst_n(rst_n), .event_i(ev.up), .busy_i(both),
      .clear_i(clear), .req_o(req.up));
   pfd_req_flop #(.HOLD_EDGES(HOLD_EDGES)) u_req_dn (
      .clk(clk), .rst_n(rst_n), .event_i(ev.dn), .busy_i(both),
      .clear_i(clear), .req_o(req.dn));

   assign up = req.up;
   assign dn = req.dn;

   // up may only fall while dn was raised, and the reverse (R2)
   assert_up_mutual_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up) |-> $past(dn));
   assert_dn_mutual_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dn) |-> $past(up));
   // a request rises only after an input event (R1)
   assert_rise_has_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up) |-> $past(ev.up));
endmodule

// File: tb/pfd_tri_state_tb_top.sv
`timescale 1ns/1ps
module pfd_tri_state_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic [3:0] reset_delay = 4'd0;
   logic       up, dn;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pfd_tri_state dut_i (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .reset_delay(reset_delay), .up(up), .dn(dn));

   // behavioural model: sample history lists plus request state
   int hr[3];
   int hf[3];
   int m_up, m_dn, m_cnt, m_pu, m_pd;

   always @(posedge clk) begin
      int er, ed;
      if (!rst_n) begin
         foreach (hr[i]) begin hr[i] = 0; hf[i] = 0; end
         m_up = 0; m_dn = 0; m_cnt = 0; m_pu = 0; m_pd = 0;
      end else begin
         er = (hr[1] == 1 && hr[2] == 0) ? 1 : 0;
         ed = (hf[1] == 1 && hf[2] == 0) ? 1 : 0;
         if (m_up == 1 && m_dn == 1 && m_cnt >= int'(reset_delay)) begin
            m_up = (m_pu == 1 || er == 1) ? 1 : 0;
            m_dn = (m_pd == 1 || ed == 1) ? 1 : 0;
            m_pu = 0; m_pd = 0; m_cnt = 0;
         end else begin
            if (m_up == 1 && m_dn == 1) begin
               m_cnt = m_cnt + 1;
               if (er == 1) m_pu = 1;
               if (ed == 1) m_pd = 1;
            end else m_cnt = 0;
            if (er == 1) m_up = 1;
            if (ed == 1) m_dn = 1;
         end
         hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = int'(ref_in);
         hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = int'(fb_in);
      end
   end

   int w_up = 0, w_dn = 0;
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         n_cmp++;
         if (int'(up) != m_up || int'(dn) != m_dn) begin
            n_bad++;
            $display("FAIL R3 per-cycle: up/dn actual %0d/%0d expected %0d/%0d",
                     up, dn, m_up, m_dn);
         end
      end
      if (up) w_up++;
      if (dn) w_dn++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pair(input int lead, input int d, input string req);
      reset_delay = 4'(d);
      @(negedge clk);
      w_up = 0; w_dn = 0;
      if (lead >= 0) begin ref_in = 1'b1; cyc(lead); fb_in = 1'b1; end
      else begin fb_in = 1'b1; cyc(-lead); ref_in = 1'b1; end
      cyc(40);
      chk(w_up == ((lead >= 0) ? lead + d + 1 : d + 1), req, w_up,
          (lead >= 0) ? lead + d + 1 : d + 1);
      chk(w_dn == ((lead >= 0) ? d + 1 : -lead + d + 1), req, w_dn,
          (lead >= 0) ? d + 1 : -lead + d + 1);
      ref_in = 1'b0; fb_in = 1'b0;
      cyc(6);
   endtask

   initial begin
      cyc(3);
      chk(up == 1'b0 && dn == 1'b0, "R6 reset", int'({up, dn}), 0);
      rst_n = 1'b1;
      cyc(10);
      chk(up == 1'b0 && dn == 1'b0, "R8 idle", int'({up, dn}), 0);

      // R1: latency from first high sample to request
      @(negedge clk); ref_in = 1'b1;
      cyc(2);
      chk(up == 1'b0, "R1 not yet", int'(up), 0);
      cyc(1);
      chk(up == 1'b1, "R1 raised", int'(up), 1);
      @(negedge clk); fb_in = 1'b1;
      cyc(20);
      ref_in = 1'b0; fb_in = 1'b0;
      cyc(6);

      pair(0, 3, "R3 coincident d=3");
      pair(0, 0, "R3 coincident d=0");
      pair(5, 2, "R4 leading ref");
      pair(-4, 1, "R4 lagging ref");
      pair(2, 15, "R4 lead with max delay");

      // R5: ref event during the overlap window is held
      reset_delay = 4'd12;
      @(negedge clk); ref_in = 1'b1; fb_in = 1'b1;
      cyc(4); ref_in = 1'b0;
      cyc(4); ref_in = 1'b1;
      cyc(12);
      chk(up == 1'b1 && dn == 1'b0, "R5 held event", int'({up, dn}), 2);
      fb_in = 1'b0; cyc(4); fb_in = 1'b1;
      cyc(20);
      chk(up == 1'b0 && dn == 1'b0, "R5 released", int'({up, dn}), 0);
      ref_in = 1'b0; fb_in = 1'b0;
      cyc(6);

      // R7: repeated ref events absorbed, one fb event clears all
      reset_delay = 4'd1;
      @(negedge clk); ref_in = 1'b1;
      cyc(4); ref_in = 1'b0;
      cyc(4); ref_in = 1'b1;
      cyc(6);
      chk(up == 1'b1 && dn == 1'b0, "R7 absorbed", int'({up, dn}), 2);
      fb_in = 1'b1;
      cyc(10);
      chk(up == 1'b0 && dn == 1'b0, "R7 single clear", int'({up, dn}), 0);
      ref_in = 1'b0; fb_in = 1'b0;
      cyc(6);

      // R6: reset mid-request
      @(negedge clk); ref_in = 1'b1;
      cyc(6);
      chk(up == 1'b1, "R6 before reset", int'(up), 1);
      rst_n = 1'b0;
      cyc(1);
      chk(up == 1'b0 && dn == 1'b0, "R6 during reset", int'({up, dn}), 0);
      ref_in = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(8);
      chk(up == 1'b0 && dn == 1'b0, "R6 after reset", int'({up, dn}), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule